// File: doc/BRIEF.md
# CPU Clock Source Selector and Divider

This block picks the CPU clock from one of four sources (main oscillator, sub oscillator, on-chip ring oscillator, PLL) and divides it down. All clocks are modelled as single-cycle tick strobes on one fast reference clock. The CPU clock leaves the block as a one-cycle enable pulse, so the block makes no derived clock. A bus-clock enable runs at the same rate as the CPU clock.

The divisor comes from a 4-bit division code register with a write port. The register holds ten legal codes, which give divisors 1, 2, 3, 4, 6, 8, 10, 12, 14 and 16. A change of source or divisor is picked up only when the divider reaches its terminal count, so no CPU clock period is ever cut short. Entry into stop or low-power mode puts the code back to divide-by-8, except when the ring oscillator is driving the CPU. The CPU therefore comes back at a middle speed when the main clock restarts.

Top module: `cpuclk_sel_div`

## Requirements
- R1: After reset the division code is 0x5 (/8), the active source is the main clock and both enables are low. With the main clock ticking, the first CPU enable follows the eighth main tick.
- R2: The requested source is decoded from the select bits in this priority order: PLL bit set gives the PLL; otherwise the ring bit set gives the ring oscillator; otherwise the sub bit set gives the sub clock; with all three clear the main clock is chosen.
- R3: Codes map to divisors as follows: 0x0=/1, 0x1=/2, 0x2=/3, 0x3=/4, 0x4=/6, 0x5=/8, 0x6=/10, 0x7=/12, 0x8=/14, 0x9=/16. The divider counts ticks of the active source, and on the tick that makes N ticks it raises cpu_en_o for one cycle, in the next clock cycle.
- R4: A write of a code above 0x9 leaves the division code unchanged.
- R5: With the sub clock active, every sub tick gives one CPU enable in the next cycle, whatever the division code.
- R6: A new source or divisor takes effect only at a terminal count. Between terminal counts the active source and divisor stay the same.
- R7: A stop or low-power request forces the code to 0x5 in the next cycle, unless the active source is the ring oscillator. The forced value wins over a write in the same cycle.
- R8: From the cycle after stop_req_i until the cycle after wake_i, no CPU enable is produced, and ticks are not counted.
- R9: bus_en_o equals cpu_en_o in every cycle.
- R10: div_code_o shows the register, and a legal write appears on it in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| main_tick_i | input | 1 | Main oscillator tick strobe |
| sub_tick_i | input | 1 | Sub oscillator tick strobe |
| ring_tick_i | input | 1 | On-chip ring oscillator tick strobe |
| pll_tick_i | input | 1 | PLL tick strobe |
| sel_sub_i | input | 1 | Request the sub clock |
| sel_ring_i | input | 1 | Request the ring oscillator |
| sel_pll_i | input | 1 | Request the PLL clock |
| div_we_i | input | 1 | Division code write strobe |
| div_wdata_i | input | 4 | Division code write data |
| stop_req_i | input | 1 | Stop mode entry strobe |
| lpm_req_i | input | 1 | Low-power mode entry strobe |
| wake_i | input | 1 | Stop mode exit strobe |
| cpu_en_o | output | 1 | CPU clock enable pulse |
| bus_en_o | output | 1 | Bus clock enable pulse |
| div_code_o | output | 4 | Current division code |

## Verification
Some rules are checked by assertions on every cycle. The code stays inside the legal range. The counter stays below the active divisor. The active source and divisor hold between terminal counts. A sub tick always gives an enable. No enable appears while stopped. The forced divide-by-8 is taken on mode entry. An illegal write leaves the code alone. The bus enable tracks the CPU enable. Other behaviour needs the bench's scenarios, which run a reference model over many cycles. These cover the exact period for each code, the select priority, the deferred switch to a new source, and the ring-oscillator exception to the forced code.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;
  localparam int NSRC     = 4;
  localparam int CODE_W   = 4;
  localparam int CNT_W    = 5;
  localparam logic [CODE_W-1:0] CODE_DIV8 = 4'h5;
  localparam logic [CODE_W-1:0] CODE_MAX  = 4'h9;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_SUB  = 2'd1,
    SRC_RING = 2'd2,
    SRC_PLL  = 2'd3
  } src_e;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return c <= CODE_MAX;
  endfunction

  // Low codes step by one, upper codes step by two.
  function automatic logic [CNT_W-1:0] code_div(input logic [CODE_W-1:0] c);
    logic [CNT_W-1:0] w;
    w = CNT_W'(c);
    if (c < 4'h4) return w + CNT_W'(1);
    else          return (w - CNT_W'(1)) << 1;
  endfunction
endpackage

// File: rtl/cpuclk_src_mux.sv
module cpuclk_src_mux
  import cpuclk_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         sel_sub_i,
  input  logic         sel_ring_i,
  input  logic         sel_pll_i,
  input  logic [N-1:0] tick_i,
  input  src_e         act_src_i,
  output src_e         req_src_o,
  output logic         src_tick_o
);
  logic [N-1:0] hit;

  always_comb begin
    if (sel_pll_i)       req_src_o = SRC_PLL;
    else if (sel_ring_i) req_src_o = SRC_RING;
    else if (sel_sub_i)  req_src_o = SRC_SUB;
    else                 req_src_o = SRC_MAIN;
  end

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = tick_i[i] && (int'(act_src_i) == i);
  end

  assign src_tick_o = |hit;
endmodule

// File: rtl/cpuclk_ctrl.sv
module cpuclk_ctrl
  import cpuclk_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          stop_req_i,
  input  logic          lpm_req_i,
  input  logic          wake_i,
  input  src_e          act_src_i,
  output logic [CW-1:0] code_o,
  output logic          stopped_o
);
  logic [CW-1:0] code_q;
  logic          stop_q;
  logic          mode_entry, force_div8, wr_ok;

  assign mode_entry = stop_req_i || lpm_req_i;
  assign force_div8 = mode_entry && (act_src_i != SRC_RING);
  assign wr_ok      = we_i && code_ok(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= CODE_DIV8;
      stop_q <= 1'b0;
    end else begin
      if (force_div8) code_q <= CODE_DIV8;
      else if (wr_ok) code_q <= wdata_i;
      if (stop_req_i)  stop_q <= 1'b1;
      else if (wake_i) stop_q <= 1'b0;
    end
  end

  assign code_o    = code_q;
  assign stopped_o = stop_q;

  a_r4_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= CODE_MAX);
  a_r4_bad_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !code_ok(wdata_i) && !mode_entry) |=> $stable(code_q));
  a_r7_mode_forces_div8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_div8 |=> (code_q == CODE_DIV8));
  a_r10_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && !mode_entry) |=> (code_q == $past(wdata_i)));
endmodule

// File: rtl/cpuclk_divider.sv
module cpuclk_divider
  import cpuclk_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int KW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          src_tick_i,
  input  logic          stopped_i,
  input  src_e          req_src_i,
  input  logic [CW-1:0] code_i,
  output logic          cpu_en_o,
  output logic          term_o,
  output src_e          act_src_o
);
  logic [KW-1:0] cnt_q, div_q;
  src_e          src_q;
  logic          en_q;
  logic          live_tick, pass_thru, at_end;

  assign live_tick = src_tick_i && !stopped_i;
  assign pass_thru = (src_q == SRC_SUB);
  assign at_end    = (cnt_q == div_q - KW'(1));
  assign term_o    = live_tick && (pass_thru || at_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= code_div(CODE_DIV8);
      src_q <= SRC_MAIN;
      en_q  <= 1'b0;
    end else begin
      en_q <= term_o;
      if (term_o) begin
        cnt_q <= '0;
        div_q <= code_div(code_i);
        src_q <= req_src_i;
      end else if (live_tick && !pass_thru) begin
        cnt_q <= cnt_q + KW'(1);
      end
    end
  end

  assign cpu_en_o  = en_q;
  assign act_src_o = src_q;

  a_r3_count_below_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div_q);
  a_r6_hold_between_terms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !term_o |=> ($stable(div_q) && $stable(src_q)));
  a_r5_sub_every_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_thru && live_tick) |=> cpu_en_o);
  a_r8_quiet_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_i |=> !cpu_en_o);
endmodule

// File: rtl/cpuclk_sel_div.sv
module cpuclk_sel_div
  import cpuclk_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int KW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          main_tick_i,
  input  logic          sub_tick_i,
  input  logic          ring_tick_i,
  input  logic          pll_tick_i,
  input  logic          sel_sub_i,
  input  logic          sel_ring_i,
  input  logic          sel_pll_i,
  input  logic          div_we_i,
  input  logic [CW-1:0] div_wdata_i,
  input  logic          stop_req_i,
  input  logic          lpm_req_i,
  input  logic          wake_i,
  output logic          cpu_en_o,
  output logic          bus_en_o,
  output logic [CW-1:0] div_code_o
);
  logic [NSRC-1:0] ticks;
  src_e            req_src, act_src;
  logic            src_tick, stopped, term;
  logic [CW-1:0]   code;
  logic            bus_q;

  assign ticks = {pll_tick_i, ring_tick_i, sub_tick_i, main_tick_i};

  cpuclk_src_mux #(.N(NSRC)) u_mux (
    .sel_sub_i  (sel_sub_i),
    .sel_ring_i (sel_ring_i),
    .sel_pll_i  (sel_pll_i),
    .tick_i     (ticks),
    .act_src_i  (act_src),
    .req_src_o  (req_src),
    .src_tick_o (src_tick)
  );

  cpuclk_ctrl #(.CW(CW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (div_we_i),
    .wdata_i    (div_wdata_i),
    .stop_req_i (stop_req_i),
    .lpm_req_i  (lpm_req_i),
    .wake_i     (wake_i),
    .act_src_i  (act_src),
    .code_o     (code),
    .stopped_o  (stopped)
  );

  cpuclk_divider #(.CW(CW), .KW(KW)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_tick_i (src_tick),
    .stopped_i  (stopped),
    .req_src_i  (req_src),
    .code_i     (code),
    .cpu_en_o   (cpu_en_o),
    .term_o     (term),
    .act_src_o  (act_src)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_q <= 1'b0;
    else         bus_q <= term;
  end

  assign bus_en_o   = bus_q;
  assign div_code_o = code;

  a_r9_bus_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o == cpu_en_o);
endmodule

// File: tb/tb_cpuclk_sel_div.sv
module tb_cpuclk_sel_div;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] tk = '0;
  logic s_sub = 0, s_ring = 0, s_pll = 0, we = 0, stp = 0, lpm = 0, wk = 0;
  logic [3:0] wd = '0;
  logic cpu_en, bus_en;
  logic [3:0] dcode;

  int checks = 0, fails = 0, en_seen = 0;
  bit done = 0;
  string tag = "R3";

  // reference model state: 0 main, 1 sub, 2 ring, 3 pll
  int m_code = 5, m_src = 0, m_div = 8, m_cnt = 0;
  bit m_stop = 0, m_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpuclk_sel_div dut (
    .clk_i(clk), .rst_ni(rst_n),
    .main_tick_i(tk[0]), .sub_tick_i(tk[1]), .ring_tick_i(tk[2]), .pll_tick_i(tk[3]),
    .sel_sub_i(s_sub), .sel_ring_i(s_ring), .sel_pll_i(s_pll),
    .div_we_i(we), .div_wdata_i(wd),
    .stop_req_i(stp), .lpm_req_i(lpm), .wake_i(wk),
    .cpu_en_o(cpu_en), .bus_en_o(bus_en), .div_code_o(dcode)
  );

  function automatic int ref_div(int c);
    case (c)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;  4: return 6;
      5: return 8;  6: return 10; 7: return 12; 8: return 14; default: return 16;
    endcase
  endfunction

  function automatic int ref_req();
    if (s_pll) return 3;
    if (s_ring) return 2;
    if (s_sub) return 1;
    return 0;
  endfunction

  task automatic check(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  // Advance model and DUT one clock, then compare at the falling edge.
  task automatic cyc();
    bit live, term;
    live = tk[m_src] && !m_stop;
    term = live && (m_src == 1 || m_cnt == m_div - 1);
    if ((stp || lpm) && m_src != 2) m_code = 5;
    else if (we && wd <= 9) m_code = wd;
    if (term) begin
      m_cnt = 0; m_div = ref_div(m_code_prev); m_src = ref_req();
    end else if (live && m_src != 1) m_cnt++;
    m_en = term;
    if (stp) m_stop = 1; else if (wk) m_stop = 0;
    m_code_prev = m_code;
    @(posedge clk);
    @(negedge clk);
    if (cpu_en) en_seen++;
    check({tag, " cpu_en"}, cpu_en, m_en);
    check("R9 bus_en", bus_en, cpu_en);
    check({"R10 ", tag, " div_code"}, dcode, m_code);
    tk = '0; we = 0; stp = 0; lpm = 0; wk = 0;
  endtask

  int m_code_prev = 5;

  task automatic run_until_src(input int s);
    for (int i = 0; i < 200 && m_src != s; i++) begin
      tk = 4'hF; cyc();
    end
    check("R2 source reached", m_src, s);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    check("R1 reset code", dcode, 5);
    check("R1 reset cpu_en", cpu_en, 0);
    check("R1 reset bus_en", bus_en, 0);

    // R1: main ticks every cycle, first enable after eighth tick
    en_seen = 0;
    for (int i = 0; i < 7; i++) begin tk[0] = 1; cyc(); end
    check("R1 no enable before 8th tick", en_seen, 0);
    tk[0] = 1; cyc();
    check("R1 enable after 8th tick", cpu_en, 1);

    // R3: code 0x2 (/3) on main
    tag = "R3";
    we = 1; wd = 4'h2; cyc();
    check("R10 legal write visible", dcode, 2);
    for (int i = 0; i < 8; i++) begin tk[0] = 1; cyc(); end
    en_seen = 0;
    for (int i = 0; i < 9; i++) begin tk[0] = 1; cyc(); end
    check("R3 /3 gives 3 enables in 9 ticks", en_seen, 3);

    // R4: illegal write ignored
    tag = "R4";
    we = 1; wd = 4'hC; cyc();
    check("R4 illegal code ignored", dcode, 2);
    we = 1; wd = 4'hF; cyc();
    check("R4 illegal code 0xF ignored", dcode, 2);

    // R6: source request deferred until terminal count (tick only PLL first)
    tag = "R6";
    s_pll = 1;
    for (int i = 0; i < 4; i++) begin tk[3] = 1; cyc(); end
    check("R6 main still active without main ticks", m_src, 0);
    check("R6 no enable from PLL ticks", en_seen, 3);

    // R2: priority, ring+sub+pll -> pll; ring+sub -> ring
    tag = "R2";
    s_sub = 1; s_ring = 1;
    run_until_src(3);
    s_pll = 0;
    run_until_src(2);
    s_ring = 0;
    run_until_src(1);

    // R5: sub passthrough regardless of code
    tag = "R5";
    we = 1; wd = 4'h9; cyc();
    for (int i = 0; i < 5; i++) begin
      tk[1] = 1; cyc();
      check("R5 sub tick gives enable", cpu_en, 1);
      cyc();
      check("R5 no enable without sub tick", cpu_en, 0);
    end

    // R7: mode entry forces /8, wins over same-cycle write
    tag = "R7";
    lpm = 1; we = 1; wd = 4'h1; cyc();
    check("R7 lpm forces code 5 over write", dcode, 5);
    s_sub = 0; s_ring = 1;
    run_until_src(2);
    we = 1; wd = 4'h3; cyc();
    lpm = 1; cyc();
    check("R7 ring source keeps code", dcode, 3);
    stp = 1; cyc();
    check("R7 stop with ring keeps code", dcode, 3);

    // R8: stopped, no enables
    tag = "R8";
    en_seen = 0;
    for (int i = 0; i < 20; i++) begin tk = 4'hF; cyc(); end
    check("R8 no enable while stopped", en_seen, 0);
    wk = 1; cyc();
    en_seen = 0;
    for (int i = 0; i < 12; i++) begin tk = 4'hF; cyc(); end
    check("R8 enables resume after wake", (en_seen > 0) ? 1 : 0, 1);

    // Random phase
    tag = "R3";
    for (int n = 0; n < 20000; n++) begin
      tk[0] = ($urandom_range(0, 9) < 6);
      tk[1] = ($urandom_range(0, 9) < 3);
      tk[2] = ($urandom_range(0, 9) < 5);
      tk[3] = ($urandom_range(0, 9) < 8);
      if ($urandom_range(0, 199) == 0) begin
        s_sub = $urandom_range(0, 1); s_ring = $urandom_range(0, 1); s_pll = $urandom_range(0, 1);
        tag = "R2";
      end
      if ($urandom_range(0, 49) == 0) begin we = 1; wd = 4'($urandom_range(0, 15)); tag = "R4"; end
      if ($urandom_range(0, 399) == 0) begin lpm = 1; tag = "R7"; end
      if ($urandom_range(0, 599) == 0) begin stp = 1; tag = "R8"; end
      if (m_stop && $urandom_range(0, 29) == 0) wk = 1;
      cyc();
      tag = "R6";
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule